// File: doc/BRIEF.md
# Periodic Rate Divider with Square Wave

This block is the time-base stage of a real-time clock. A 22-stage binary divider chain advances one count on each enable pulse. Each enable pulse marks one edge of a 32.768 kHz oscillator that has already been synchronised to the system clock. The chain produces three outputs:

- a once-per-second calendar tick;
- a periodic tick at a rate chosen by a 4-bit rate selector;
- a 50% duty-cycle square wave taken from the same divider stage as the periodic tick.

Interrupt flag handling and calendar counting belong to neighbouring blocks. Those blocks consume the single-cycle ticks.

A 3-bit divider-control field sets the mode of the chain. One code lets it count, two codes hold it cleared, and every other code freezes it at its current value. Releasing the chain from the cleared state places the first calendar tick half a second later. This lets software start the clock on a known boundary.

Top module: `rate_divider`

## Requirements
- R1: While rstN is low, and in the first cycle after it rises, secTick, periodicTick and sqwOut are all 0 and the divider chain is cleared.
- R2: divCtl values 3'b110 and 3'b111 hold the chain at zero. While such a code is applied, oscTick pulses produce no secTick or periodicTick and sqwOut stays 0. After release, counting restarts from zero.
- R3: With divCtl = 3'b010 the chain advances by exactly one count for each cycle in which oscTick is high.
- R4: Any other divCtl value (3'b000, 001, 011, 100, 101) freezes the chain at its count: no ticks are produced and sqwOut does not change. Counting resumes from the frozen value when 3'b010 returns.
- R5: After the chain leaves the cleared state with divCtl = 3'b010, the first secTick follows the 16384th oscTick (500 ms). Further secTicks follow every 32768 oscTicks (1 s).
- R6: rateSel selects the tap. rateSel 1 gives a period of 128 oscTicks (256 Hz). rateSel 2 gives 256 oscTicks (128 Hz). rateSel n in 3..15 gives a period of 2^(n-1) oscTicks, so 3 gives 8192 Hz and 15 gives 2 Hz.
- R7: rateSel = 0 selects no tap: periodicTick never pulses and sqwOut stays 0.
- R8: periodicTick and secTick are single-cycle pulses. Each is raised in the cycle after the oscTick cycle in which the selected stage (or the one-second stage) goes from 0 to 1.
- R9: When sqwEn = 1 and a tap is selected, sqwOut equals the selected stage, which gives a 50% duty cycle. When sqwEn = 0, sqwOut is 0 while periodicTick keeps pulsing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| oscTick | input | 1 | One-cycle pulse per synchronised 32.768 kHz oscillator edge |
| divCtl | input | 3 | Divider mode: 010 count, 11x hold cleared, others freeze |
| rateSel | input | 4 | Tap select for periodic tick and square wave, 0 = off |
| sqwEn | input | 1 | Square-wave output enable |
| secTick | output | 1 | One-cycle pulse once per second for the calendar |
| periodicTick | output | 1 | One-cycle pulse at the selected rate |
| sqwOut | output | 1 | Square wave at the selected rate, low when disabled |

## Verification
The hardest situation to reach is the half-second first tick after a hold release followed by the full one-second interval. That needs about fifty thousand oscillator edges. The bench drives oscTick every second clock cycle and counts the edges itself. The freeze and clear codes are harder to tell apart from ports alone. The bench therefore stops the chain one edge before a rise of the fastest tap and counts the edges to the next periodic pulse: one edge means the count was held, two means it was cleared.

// File: rtl/rate_div_pkg.sv
package rate_div_pkg;
  localparam int DIV_STAGES  = 22;
  localparam int TAP_W       = $clog2(DIV_STAGES);
  localparam int OSC_LOG2    = 15;            // 32768 edges per second
  localparam int SEC_STAGE   = OSC_LOG2 - 1;  // rises every 2^15 edges
  localparam int STAGE_256HZ = 6;
  localparam int STAGE_128HZ = 7;
  localparam int FAST_OFFSET = 2;             // rateSel n>=3 -> stage n-2
  localparam int SEL_W       = 4;
  localparam int MODE_W      = 3;
  localparam logic [MODE_W-1:0] MODE_RUN = 3'b010;

  typedef struct packed {
    logic             run;
    logic             clr;
    logic             tapValid;
    logic             sqwGate;
    logic [TAP_W-1:0] tapIdx;
  } divStrobeT;
endpackage

// File: rtl/rate_div_ctrl.sv
module rate_div_ctrl
  import rate_div_pkg::*;
(
  input  logic [MODE_W-1:0] divCtl,
  input  logic [SEL_W-1:0]  rateSel,
  input  logic              sqwEn,
  output divStrobeT         strobe
);
  logic [TAP_W-1:0] idx;
  logic             valid;

  always_comb begin
    valid = 1'b1;
    idx   = '0;
    unique case (rateSel)
      4'd0:    valid = 1'b0;
      4'd1:    idx = TAP_W'(STAGE_256HZ);
      4'd2:    idx = TAP_W'(STAGE_128HZ);
      default: idx = TAP_W'(rateSel) - TAP_W'(FAST_OFFSET);
    endcase
  end

  always_comb begin
    strobe.clr      = divCtl[2] & divCtl[1];
    strobe.run      = (divCtl == MODE_RUN);
    strobe.tapValid = valid;
    strobe.sqwGate  = sqwEn & valid;
    strobe.tapIdx   = idx;
  end

  always_comb begin
    if (valid === 1'b1)
      AST_TAP_RANGE: assert (idx >= TAP_W'(1) && idx <= TAP_W'(13)); // R6
  end
endmodule

// File: rtl/rate_div_path.sv
module rate_div_path
  import rate_div_pkg::*;
#(
  parameter int STAGES = DIV_STAGES
)(
  input  logic      clk,
  input  logic      rstN,
  input  logic      oscTick,
  input  divStrobeT strobe,
  output logic      secTick,
  output logic      periodicTick,
  output logic      sqwOut
);
  logic [STAGES-1:0] stageQ;
  logic [STAGES-1:0] stageD;
  logic [STAGES-1:0] carry;

  assign carry[0] = oscTick & strobe.run & ~strobe.clr;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k > 0) begin : g_carry
      assign carry[k] = carry[k-1] & stageQ[k-1];
    end
    assign stageD[k] = strobe.clr ? 1'b0 : (stageQ[k] ^ carry[k]);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stageQ[k] <= 1'b0;
      else       stageQ[k] <= stageD[k];
    end
  end

  logic tapRise;
  logic secRise;
  assign tapRise = strobe.tapValid & carry[strobe.tapIdx] & ~stageQ[strobe.tapIdx];
  assign secRise = carry[SEC_STAGE] & ~stageQ[SEC_STAGE];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secTick      <= 1'b0;
      periodicTick <= 1'b0;
      sqwOut       <= 1'b0;
    end else begin
      secTick      <= secRise;
      periodicTick <= tapRise;
      sqwOut       <= strobe.sqwGate & stageD[strobe.tapIdx];
    end
  end

  AST_CLEAR_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clr |=> (stageQ == '0)); // R2
  AST_FREEZE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.run && !strobe.clr) |=> $stable(stageQ)); // R4
  AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !(oscTick && strobe.run && !strobe.clr) |=> (!secTick && !periodicTick)); // R8
  AST_PTICK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    periodicTick |=> !periodicTick); // R8
  AST_STICK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    secTick |=> !secTick); // R8
  AST_SQW_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.sqwGate |=> !sqwOut); // R9
  AST_RUN_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (oscTick && strobe.run && !strobe.clr) |=> (stageQ == $past(stageQ) + 1'b1)); // R3
endmodule

// File: rtl/rate_divider.sv
module rate_divider
  import rate_div_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              oscTick,
  input  logic [MODE_W-1:0] divCtl,
  input  logic [SEL_W-1:0]  rateSel,
  input  logic              sqwEn,
  output logic              secTick,
  output logic              periodicTick,
  output logic              sqwOut
);
  divStrobeT strobe;

  rate_div_ctrl u_ctrl (
    .divCtl  (divCtl),
    .rateSel (rateSel),
    .sqwEn   (sqwEn),
    .strobe  (strobe)
  );

  rate_div_path #(.STAGES(DIV_STAGES)) u_path (
    .clk          (clk),
    .rstN         (rstN),
    .oscTick      (oscTick),
    .strobe       (strobe),
    .secTick      (secTick),
    .periodicTick (periodicTick),
    .sqwOut       (sqwOut)
  );
endmodule

// File: tb/rate_divider_tb.sv
module rate_divider_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic oscTick = 1'b0;
  logic [2:0] divCtl = 3'b110;
  logic [3:0] rateSel = 4'd3;
  logic sqwEn = 1'b1;
  logic secTick, periodicTick, sqwOut;

  int checks = 0;
  int failures = 0;
  logic sSmp, pSmp, wSmp;

  always #10 clk = ~clk;  // 50 MHz

  rate_divider u_dut (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .divCtl(divCtl),
    .rateSel(rateSel), .sqwEn(sqwEn), .secTick(secTick),
    .periodicTick(periodicTick), .sqwOut(sqwOut)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) oscTick = 1'b1;
    @(negedge clk) oscTick = 1'b0;
    sSmp = secTick; pSmp = periodicTick; wSmp = sqwOut;
  endtask

  task automatic countToPer(input int limit, output int n);
    n = 0;
    do begin tick(); n++; end while (!pSmp && n < limit);
    @(negedge clk);
    if (pSmp) check("R8 periodic pulse width", periodicTick, 0);
  endtask

  task automatic countToSec(input int limit, output int n);
    n = 0;
    do begin tick(); n++; end while (!sSmp && n < limit);
    @(negedge clk);
    if (sSmp) check("R8 second pulse width", secTick, 0);
  endtask

  task automatic clearChain();
    divCtl = 3'b110; tick(); divCtl = 3'b010;
  endtask

  task automatic t_reset();
    check("R1 secTick", secTick, 0);
    check("R1 periodicTick", periodicTick, 0);
    check("R1 sqwOut", sqwOut, 0);
  endtask

  task automatic t_hold();
    int hits = 0;
    divCtl = 3'b110;
    for (int i = 0; i < 8; i++) begin tick(); hits += sSmp + pSmp + wSmp; end
    divCtl = 3'b111;
    for (int i = 0; i < 8; i++) begin tick(); hits += sSmp + pSmp + wSmp; end
    check("R2 activity while held", hits, 0);
  endtask

  task automatic t_seconds();
    int n;
    rateSel = 4'd0;
    divCtl = 3'b010;
    countToSec(20000, n);
    check("R5 first second edges", n, 16384);
    countToSec(40000, n);
    check("R5 second interval edges", n, 32768);
  endtask

  task automatic t_rates();
    int n;
    clearChain();
    rateSel = 4'd3; countToPer(16, n);
    countToPer(16, n);      check("R6 rateSel 3 period", n, 4);
    rateSel = 4'd1; countToPer(300, n);
    countToPer(300, n);     check("R6 rateSel 1 period", n, 128);
    rateSel = 4'd2; countToPer(600, n);
    countToPer(600, n);     check("R6 rateSel 2 period", n, 256);
    rateSel = 4'd13; countToPer(9000, n);
    countToPer(9000, n);    check("R6 rateSel 13 period", n, 4096);
  endtask

  task automatic t_sqw();
    int n, highs, pulses;
    rateSel = 4'd3; sqwEn = 1'b1;
    countToPer(16, n);
    highs = 0;
    for (int i = 0; i < 16; i++) begin tick(); highs += wSmp; end
    check("R9 duty highs of 16", highs, 8);
    sqwEn = 1'b0; highs = 0; pulses = 0;
    for (int i = 0; i < 16; i++) begin tick(); highs += wSmp; pulses += pSmp; end
    check("R9 sqw low when disabled", highs, 0);
    check("R9 ticks continue when disabled", pulses, 4);
    sqwEn = 1'b1;
  endtask

  task automatic t_zero();
    int hits = 0;
    rateSel = 4'd0;
    for (int i = 0; i < 64; i++) begin tick(); hits += pSmp + wSmp; end
    check("R7 no output at rateSel 0", hits, 0);
  endtask

  task automatic t_freeze();
    int n, hits;
    logic w0;
    rateSel = 4'd3;
    clearChain();
    tick();                 // count = 1
    w0 = wSmp;
    divCtl = 3'b000; hits = 0;
    for (int i = 0; i < 10; i++) begin tick(); hits += pSmp + int'(wSmp != w0); end
    divCtl = 3'b101;
    for (int i = 0; i < 10; i++) begin tick(); hits += pSmp + int'(wSmp != w0); end
    check("R4 activity while frozen", hits, 0);
    divCtl = 3'b010;
    countToPer(16, n);
    check("R4 resume keeps count", n, 1);
    check("R3 one count per edge", n, 1);
    clearChain();
    tick();                 // count = 1
    divCtl = 3'b110; tick();
    divCtl = 3'b010;
    countToPer(16, n);
    check("R2 release restarts from zero", n, 2);
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_hold();
    t_seconds();
    t_rates();
    t_sqw();
    t_zero();
    t_freeze();
    finishRun();
  end
endmodule